// File: doc/BRIEF.md
# Parallel EPROM read controller

This block sits on the system side of an asynchronous parallel EPROM organised as 16-bit words. It accepts read requests through a valid/ready handshake. For each request it drives the word address, the chip-enable and output-enable strobes and the width select. It waits clock-counted windows derived from the part's access times, latches the data and returns it with a single-cycle valid pulse. Each request chooses a 16-bit word read or an 8-bit byte read.

In byte mode the part's top data pin becomes the lowest address input, so the controller turns that pin around and drives it with the byte-lane bit of the request. Any change of width select gets its own settling wait, during which chip enable stays high. Between accesses the part is left deselected, which puts it in standby. Every timing window is a parameter in picoseconds that is converted to whole clock cycles, always rounding up.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is asserted and right after it, mem_ce_n=1, mem_oe_n=1, mem_byte_n=1 (word width), mem_q15_oe=0, rsp_valid=0 and req_ready=1.
- R2: When req_byte=0 the controller reads the word at address req_addr[ADDR_W:1] and returns {mem_q15_in, mem_dq_in[14:0]}. req_addr[0] has no effect on the result, and mem_q15_oe stays 0.
- R3: When req_byte=1 the controller drives mem_byte_n=0 and mem_q15_oe=1, with mem_q15_out=req_addr[0] (1 selects the upper byte of the word). It returns {8'h00, mem_dq_in[7:0]}, with the upper result bits zero.
- R4: Output enable falls only after chip enable has been low with a stable address for LEAD_CYC cycles. Data is latched after output enable has been low for OEW_CYC cycles. With no width change, rsp_valid is seen LEAD_CYC+OEW_CYC+1 cycles after the accepting edge.
- R5: mem_oe_n is low only while mem_ce_n is low.
- R6: After the data is latched, both strobes stay high for DF_CYC cycles before req_ready returns to 1. req_ready is 0 throughout an access.
- R7: A request whose width differs from the current select first changes mem_byte_n. The access then starts after SELHI_CYC cycles (switch to word) or SELLO_CYC cycles (switch to byte), which adds that many cycles to the R4 latency.
- R8: Each accepted request gives exactly one rsp_valid pulse, one cycle long. An access cut short by reset gives none.
- R9: While mem_ce_n stays low, mem_addr, mem_byte_n, mem_q15_out and mem_q15_oe do not change.
- R10: Whenever the controller is ready for a request, mem_ce_n is 1 (standby).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| req_addr | input | ADDR_W+1 | Byte address; [ADDR_W:1] word, [0] byte lane |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 16 | Read result, byte results zero-extended |
| mem_addr | output | ADDR_W | Word address to the EPROM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_byte_n | output | 1 | Width select, 1 = word, 0 = byte |
| mem_q15_out | output | 1 | Value for the shared pin in byte mode (lane bit) |
| mem_q15_oe | output | 1 | Drive enable for the shared pin |
| mem_q15_in | input | 1 | Shared pin as data bit 15 in word mode |
| mem_dq_in | input | 15 | Data bits 14..0 from the EPROM |

## Verification
The assertions check the strobe and pin rules on every cycle. These cover output enable only under chip enable, a frozen address, select and lane pin while the chip is selected, the exact lead and output-enable cycle counts, the float wait before readiness, and the single-cycle result strobe. Only the bench scenarios can show correct data and latency. A timed EPROM model returns garbage when its access, output-enable or select-settling times are not met, so correct data shows that the windows are long enough. The scenarios also cover byte-lane choice, zero extension, the extra wait on each width switch and the dropped result of an access cut short by reset.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEL   = 3'd1,
        ST_LEAD  = 3'd2,
        ST_OEW   = 3'd3,
        ST_FLOAT = 3'd4
    } rd_state_e;

    // Whole clock cycles that cover a time, rounding up.
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                              input int unsigned per_ps);
        return (t_ps + per_ps - 1) / per_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a,
                                         input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_wait_timer.sv
`timescale 1ns/1ps
module eprom_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // A window of len cycles: loaded with len-1, expired when it reaches zero.
    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R4: an expired window stays expired until it is restarted
    a_r4_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> expired);

endmodule

// File: rtl/eprom_lane_steer.sv
`timescale 1ns/1ps
module eprom_lane_steer (
    input  logic        byte_mode,
    input  logic        q15_in,
    input  logic [14:0] dq_in,
    output logic [15:0] data
);
    // Word: shared pin is bit 15. Byte: the part puts the chosen lane on the
    // low eight pins, and the floating upper pins are discarded.
    always_comb begin
        if (byte_mode) begin
            data = {8'h00, dq_in[7:0]};
        end else begin
            data = {q15_in, dq_in};
        end
    end

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned T_ACC_PS      = 70000,
    parameter int unsigned T_OE_PS       = 35000,
    parameter int unsigned T_DF_PS       = 30000,
    parameter int unsigned T_SELHI_PS    = 70000,
    parameter int unsigned T_SELLO_PS    = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_byte,
    input  logic [ADDR_W:0]   req_addr,
    output logic              rsp_valid,
    output logic [15:0]       rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_byte_n,
    output logic              mem_q15_out,
    output logic              mem_q15_oe,
    input  logic              mem_q15_in,
    input  logic [14:0]       mem_dq_in
);
    localparam int unsigned ACC_CYC   = ps_to_cyc(T_ACC_PS, CLK_PERIOD_PS);
    localparam int unsigned OE_RAW    = ps_to_cyc(T_OE_PS, CLK_PERIOD_PS);
    localparam int unsigned LEAD_CYC  = umax(1, ps_to_cyc(T_ACC_PS - T_OE_PS, CLK_PERIOD_PS));
    localparam int unsigned OEW_CYC   = umax(1, umax(OE_RAW, ACC_CYC - LEAD_CYC));
    localparam int unsigned DF_CYC    = umax(1, ps_to_cyc(T_DF_PS, CLK_PERIOD_PS));
    localparam int unsigned SELHI_CYC = umax(1, ps_to_cyc(T_SELHI_PS, CLK_PERIOD_PS));
    localparam int unsigned SELLO_CYC = umax(1, ps_to_cyc(T_SELLO_PS, CLK_PERIOD_PS));
    localparam int unsigned MAX_CYC   = umax(umax(LEAD_CYC, OEW_CYC),
                                             umax(DF_CYC, umax(SELHI_CYC, SELLO_CYC)));
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        rd_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              lane;
        logic              sel_word;
        logic              ce_n;
        logic              oe_n;
        logic              vld;
        logic [15:0]       data;
    } ctrl_regs_t;

    ctrl_regs_t       r_d, r_q;
    logic             tmr_start;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_expired;
    logic [15:0]      steered;

    eprom_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .len     (tmr_len),
        .expired (tmr_expired)
    );

    eprom_lane_steer u_steer (
        .byte_mode (!r_q.sel_word),
        .q15_in    (mem_q15_in),
        .dq_in     (mem_dq_in),
        .data      (steered)
    );

    always_comb begin
        r_d       = r_q;
        r_d.vld   = 1'b0;
        tmr_start = 1'b0;
        tmr_len   = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr     = req_addr[ADDR_W:1];
                    r_d.lane     = req_addr[0];
                    r_d.sel_word = !req_byte;
                    tmr_start    = 1'b1;
                    if ((!req_byte) != r_q.sel_word) begin
                        r_d.st  = ST_SEL;
                        tmr_len = req_byte ? CNT_W'(SELLO_CYC) : CNT_W'(SELHI_CYC);
                    end else begin
                        r_d.st   = ST_LEAD;
                        r_d.ce_n = 1'b0;
                        tmr_len  = CNT_W'(LEAD_CYC);
                    end
                end
            end
            ST_SEL: begin
                if (tmr_expired) begin
                    r_d.st    = ST_LEAD;
                    r_d.ce_n  = 1'b0;
                    tmr_start = 1'b1;
                    tmr_len   = CNT_W'(LEAD_CYC);
                end
            end
            ST_LEAD: begin
                if (tmr_expired) begin
                    r_d.st    = ST_OEW;
                    r_d.oe_n  = 1'b0;
                    tmr_start = 1'b1;
                    tmr_len   = CNT_W'(OEW_CYC);
                end
            end
            ST_OEW: begin
                if (tmr_expired) begin
                    r_d.st    = ST_FLOAT;
                    r_d.data  = steered;
                    r_d.vld   = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    tmr_start = 1'b1;
                    tmr_len   = CNT_W'(DF_CYC);
                end
            end
            ST_FLOAT: begin
                if (tmr_expired) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.addr     <= '0;
            r_q.lane     <= 1'b0;
            r_q.sel_word <= 1'b1;
            r_q.ce_n     <= 1'b1;
            r_q.oe_n     <= 1'b1;
            r_q.vld      <= 1'b0;
            r_q.data     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign rsp_valid   = r_q.vld;
    assign rsp_data    = r_q.data;
    assign mem_addr    = r_q.addr;
    assign mem_ce_n    = r_q.ce_n;
    assign mem_oe_n    = r_q.oe_n;
    assign mem_byte_n  = r_q.sel_word;
    assign mem_q15_oe  = !r_q.sel_word;
    assign mem_q15_out = r_q.lane & !r_q.sel_word;

    // ---------------- checks on the bus sequencing ----------------
    localparam int KW = CNT_W + 1;
    logic [KW-1:0] ce_low_cnt, oe_low_cnt, idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_low_cnt <= '0;
            oe_low_cnt <= '0;
            idle_cnt   <= '0;
        end else begin
            ce_low_cnt <= mem_ce_n ? '0 : ((&ce_low_cnt) ? ce_low_cnt : ce_low_cnt + 1'b1);
            oe_low_cnt <= mem_oe_n ? '0 : ((&oe_low_cnt) ? oe_low_cnt : oe_low_cnt + 1'b1);
            idle_cnt   <= (mem_ce_n && mem_oe_n)
                          ? ((&idle_cnt) ? idle_cnt : idle_cnt + 1'b1) : '0;
        end
    end

    // R5: output enable only under chip enable
    a_r5_oe_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ce_n);

    // R9: bus frozen while the chip is selected
    a_r9_bus_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |->
            ($stable(mem_addr) && $stable(mem_byte_n) &&
             $stable(mem_q15_out) && $stable(mem_q15_oe)));

    // R4: output enable falls after exactly the lead window
    a_r4_oe_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (ce_low_cnt == KW'(LEAD_CYC)));

    // R4: data latched after exactly the output-enable window
    a_r4_capture_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (oe_low_cnt == KW'(OEW_CYC)));

    // R6: float time observed before the next request can be taken
    a_r6_float_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (idle_cnt >= KW'(DF_CYC)));

    // R8: result strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: standby whenever a request can be accepted
    a_r10_standby: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n));

    // R3: shared pin driven exactly in byte width
    a_r3_pin_dir: assert property (@(posedge clk) disable iff (!rst_n)
        mem_q15_oe == !mem_byte_n);

endmodule

// File: tb/tb_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_eprom_rd_ctrl;
    localparam int AW     = 19;
    localparam int PER_PS = 8000;
    // Expected cycle counts at 125 MHz for the default 70 ns timing set.
    localparam int LEAD  = 5;   // ceil(35 ns / 8 ns)
    localparam int OEW   = 5;   // max(ceil(35/8), ceil(70/8)-LEAD)
    localparam int DF    = 4;   // ceil(30/8)
    localparam int SELHI = 9;   // ceil(70/8)
    localparam int SELLO = 4;   // ceil(30/8)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_byte = 1'b0;
    logic [AW:0]   req_addr = '0;
    logic          req_ready, rsp_valid;
    logic [15:0]   rsp_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_byte_n, mem_q15_out, mem_q15_oe;
    logic          mem_q15_in = 1'b1;
    logic [14:0]   mem_dq_in = 15'h2AAA;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;
    logic cur_byte = 1'b0;

    always #4 clk = ~clk;

    eprom_rd_ctrl #(.ADDR_W(AW), .CLK_PERIOD_PS(PER_PS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_byte(req_byte), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_byte_n(mem_byte_n), .mem_q15_out(mem_q15_out),
        .mem_q15_oe(mem_q15_oe), .mem_q15_in(mem_q15_in), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [15:0] rom_word(input logic [AW-1:0] wa);
        logic [31:0] t;
        t = {13'h0, wa} * 32'h9E3779B1;
        return t[31:16] ^ t[15:0];
    endfunction

    function automatic logic [15:0] exp_data(input logic b, input logic [AW:0] a);
        logic [15:0] w;
        w = rom_word(a[AW:1]);
        if (!b) return w;
        return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    // ---------------- timed EPROM model ----------------
    time t_addr = 0, t_oe = 0, t_sel = 0;
    always @(mem_addr or mem_q15_out or mem_q15_oe or mem_byte_n or mem_ce_n) t_addr = $time;
    always @(mem_oe_n) t_oe = $time;
    always @(mem_byte_n) t_sel = $time;

    always @(negedge clk) begin
        time nxt;
        logic [15:0] w;
        nxt = $time + 4;
        w = rom_word(mem_addr);
        if (!mem_ce_n && !mem_oe_n && (nxt - t_addr >= 70) && (nxt - t_oe >= 35)) begin
            if (mem_byte_n && (nxt - t_sel >= 70)) begin
                mem_q15_in <= w[15];
                mem_dq_in  <= w[14:0];
            end else if (!mem_byte_n) begin
                mem_q15_in <= 1'b0;
                mem_dq_in  <= {7'h55, (mem_q15_out ? w[15:8] : w[7:0])};
            end else begin
                mem_q15_in <= 1'b1;
                mem_dq_in  <= 15'h2AAA;
            end
        end else begin
            mem_q15_in <= 1'b1;
            mem_dq_in  <= 15'h2AAA;
        end
    end

    // ---------------- port monitors for R5 / R9 ----------------
    int   viol_r5 = 0, viol_r9 = 0;
    logic p_ce_n = 1'b1, p_byte_n = 1'b1, p_q15o = 1'b0, p_q15e = 1'b0;
    logic [AW-1:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n && mem_ce_n) viol_r5++;
            if (!mem_ce_n && !p_ce_n &&
                (mem_addr != p_addr || mem_byte_n != p_byte_n ||
                 mem_q15_out != p_q15o || mem_q15_oe != p_q15e)) viol_r9++;
        end
        p_ce_n = mem_ce_n; p_addr = mem_addr; p_byte_n = mem_byte_n;
        p_q15o = mem_q15_out; p_q15e = mem_q15_oe;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_read(input logic b, input logic [AW:0] a);
        int lat;
        int n;
        int exp_lat;
        bit sw;
        sw = (b != cur_byte);
        exp_lat = (sw ? (b ? SELLO : SELHI) : 0) + LEAD + OEW + 1;
        @(negedge clk);
        req_valid = 1'b1; req_byte = b; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        if (b) chk(rsp_data == exp_data(b, a), "R3 byte data", rsp_data, exp_data(b, a));
        else   chk(rsp_data == exp_data(b, a), "R2 word data", rsp_data, exp_data(b, a));
        if (sw) chk(lat == exp_lat, "R7 latency with width switch", lat, exp_lat);
        else    chk(lat == exp_lat, "R4 latency", lat, exp_lat);
        chk(mem_q15_oe == b, "R3 shared pin direction", mem_q15_oe, b);
        if (b) chk(mem_q15_out == a[0], "R3 lane bit on shared pin", mem_q15_out, a[0]);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk(!rsp_valid, "R8 one-cycle strobe", rsp_valid, 0);
        end while (!req_ready && n < 100);
        chk(n == DF, "R6 float wait before ready", n, DF);
        chk(mem_ce_n && mem_oe_n, "R10 standby when ready", {mem_ce_n, mem_oe_n}, 2'b11);
        cur_byte = b;
    endtask

    // Stimulus table: {req_byte, req_addr}
    localparam int NV = 12;
    localparam logic [AW+1:0] VEC [NV] = '{
        {1'b0, 20'h00000}, {1'b0, 20'h00001}, {1'b0, 20'hFFFFE},
        {1'b1, 20'h00010}, {1'b1, 20'h00011}, {1'b1, 20'hFFFFF},
        {1'b0, 20'h12346}, {1'b1, 20'h0ABCD}, {1'b1, 20'h0ABCC},
        {1'b0, 20'h55554}, {1'b0, 20'hAAAAA}, {1'b1, 20'h7FFFE}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(mem_ce_n && mem_oe_n && mem_byte_n && !mem_q15_oe && !rsp_valid,
            "R1 reset outputs", {mem_ce_n, mem_oe_n, mem_byte_n, mem_q15_oe, rsp_valid}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n, "R1 ready after reset", {req_ready, mem_ce_n}, 2'b11);

        for (int i = 0; i < NV; i++) begin
            run_read(VEC[i][AW+1], VEC[i][AW:0]);
        end

        // R2: address bit 0 ignored on word reads
        run_read(1'b0, 20'h3C3C3);
        run_read(1'b0, 20'h3C3C2);

        // R1 / R8: reset in the middle of a byte access
        @(negedge clk);
        req_valid = 1'b1; req_byte = 1'b1; req_addr = 20'h01235;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (SELLO + 2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_byte_n && !mem_q15_oe,
            "R1 reset aborts access", {mem_ce_n, mem_oe_n, mem_byte_n, mem_q15_oe}, 4'b1110);
        rst_n = 1'b1;
        begin
            int seen;
            seen = 0;
            repeat (20) begin
                @(negedge clk);
                if (rsp_valid) seen++;
            end
            chk(seen == 0, "R8 no result for aborted access", seen, 0);
        end
        cur_byte = 1'b0;
        run_read(1'b1, 20'h01235);
        run_read(1'b0, 20'h01234);

        chk(viol_r5 == 0, "R5 oe only under ce", viol_r5, 0);
        chk(viol_r9 == 0, "R9 bus frozen while selected", viol_r9, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule